// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block derives the 16x oversampling strobe that a UART receiver and transmitter run from, using only the core clock. Two stages do the division. The first is a power-of-two prescaler. Its exponent is the sum of two small configuration fields: a 3-bit coarse field and a 2-bit fine field. The second stage stretches the prescaled rate by a ratio of 1 + F/64, where F is a 6-bit fraction. A phase accumulator spreads the extra prescaled periods evenly over time.

The block has two outputs. The oversample strobe is a single-cycle pulse. A bit-rate strobe marks every sixteenth oversample strobe. The achieved bit rate is Fcore / (16 × 2^exp × (1 + F/64)). For example, a 4.096 MHz clock with exponent 4 and fraction 0x2B gives a bit period of 428 clocks, which is about 9570 bps. That is roughly 0.31 % below a 9600 target.

A new setting never cuts an oversample period short. It is adopted only at the next oversample boundary. While the enable is low, the block is silent and all its counting state is zero.

Top module: `frac_baud_gen`

## Requirements
- R1: While rst_n is low, os_tick and bit_tick are low, whatever the other inputs.
- R2: The exponent is div_sel + thr_sel (0 to 10). With frac_sel = 0, os_tick pulses once every 2^exp clocks. When exp = 0 and frac_sel = 0, os_tick is high on every cycle.
- R3: Over any 64 consecutive os_tick pulses, the total length is exactly 64 × 2^exp × (1 + frac_sel/64) clocks. The bit period therefore averages 16 × 2^exp × (64 + frac_sel)/64 clocks, and a measurement over N bits lies within N clocks of that value.
- R4: Each interval between consecutive os_tick pulses is either 2^exp or 2^(exp+1) clocks. Exactly frac_sel of every 64 consecutive intervals are the longer kind.
- R5: bit_tick is high only in a cycle where os_tick is high. It is high on every sixteenth os_tick, counted from the start of enable.
- R6: While enable is low, no tick is produced and the counters and accumulator are zero. The cycle in which enable first reads high shows no tick. The first os_tick appears 2^exp clocks after the first enabled clock edge, and the first bit_tick comes with the sixteenth os_tick.
- R7: A change of div_sel, thr_sel or frac_sel while enabled takes effect at the next os_tick boundary. The interval in progress completes with the old setting. The intervals after it use the new setting, with the accumulator restarted from zero.
- R8: With div_sel = 3, thr_sel = 1 and frac_sel = 0x2B, the bit period averages 428 clocks. That equals 9570 bps at a 4.096 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low clears and silences it |
| div_sel | input | 3 | Coarse exponent field |
| thr_sel | input | 2 | Fine exponent field, added to div_sel |
| frac_sel | input | 6 | Fraction F of the 1 + F/64 stretch |
| os_tick | output | 1 | Single-cycle oversample strobe |
| bit_tick | output | 1 | Strobe on every sixteenth os_tick |

## Verification
The rate is measured with several settings:
- exp 0 with no fraction, where the strobe is continuously high;
- exp 0 with the largest fraction;
- a mid exponent with fraction 63;
- the 9600-baud example;
- the maximum exponent of 10, which reaches only through both fields together.

These show whether the exponent fields are summed, whether the fraction is weighted per step of 1/64, and whether the accumulator carry is lost at its limits. A half-scale fraction is checked interval by interval, which separates a correct single-period stretch from an averaged-but-lumpy one. Start-up latency, silence while disabled, and a mid-run exponent change each check a separate timing rule at the strobe boundaries.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int unsigned DIV_W_DEF  = 3;
  localparam int unsigned THR_W_DEF  = 2;
  localparam int unsigned FRAC_W_DEF = 6;
  localparam int unsigned OSR_DEF    = 16;
endpackage

// File: rtl/fbg_cfg_hold.sv
// Active configuration: follows the inputs while disabled, and while
// enabled is reloaded only at an oversample boundary.
module fbg_cfg_hold #(
  parameter int unsigned DIV_W  = 3,
  parameter int unsigned THR_W  = 2,
  parameter int unsigned FRAC_W = 6,
  parameter int unsigned EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              boundary,
  input  logic [DIV_W-1:0]  div_in,
  input  logic [THR_W-1:0]  thr_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [EXP_W-1:0]  exp_act,
  output logic [FRAC_W-1:0] frac_act,
  output logic              reload
);
  logic [DIV_W-1:0]  div_q, div_n;
  logic [THR_W-1:0]  thr_q, thr_n;
  logic [FRAC_W-1:0] frac_q, frac_n;
  logic              differs;
  logic              take;

  always_comb begin
    differs = (div_in != div_q) || (thr_in != thr_q) || (frac_in != frac_q);
    reload  = enable && boundary && differs;
    take    = !enable || reload;
    div_n   = take ? div_in  : div_q;
    thr_n   = take ? thr_in  : thr_q;
    frac_n  = take ? frac_in : frac_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      thr_q  <= '0;
      frac_q <= '0;
    end else begin
      div_q  <= div_n;
      thr_q  <= thr_n;
      frac_q <= frac_n;
    end
  end

  assign exp_act  = EXP_W'(div_q) + EXP_W'(thr_q);
  assign frac_act = frac_q;
endmodule

// File: rtl/fbg_prescaler.sv
// Power-of-two prescaler: one pulse every 2^exp_act clocks.
module fbg_prescaler #(
  parameter int unsigned EXP_W = 4,
  parameter int unsigned PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [EXP_W-1:0] exp_act,
  output logic             pre_tick
);
  logic [PRE_W-1:0] cnt_q, cnt_n;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W:0]   limit;

  always_comb begin
    one_sh   = {{PRE_W{1'b0}}, 1'b1} << exp_act;
    limit    = one_sh - {{PRE_W{1'b0}}, 1'b1};
    pre_tick = enable && ({1'b0, cnt_q} == limit);
    if (!enable || pre_tick) cnt_n = '0;
    else                     cnt_n = cnt_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/fbg_frac_stage.sv
// Fractional stretch: each emitted period adds F to a phase accumulator;
// a carry swallows the next prescaled pulse.
module fbg_frac_stage #(
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pre_tick,
  input  logic [FRAC_W-1:0] frac_act,
  input  logic              reload,
  output logic              os_fire
);
  logic [FRAC_W-1:0] acc_q, acc_n;
  logic              hold_q, hold_n;
  logic [FRAC_W:0]   sum;

  always_comb begin
    os_fire = pre_tick && !hold_q;
    sum     = {1'b0, acc_q} + {1'b0, frac_act};
    acc_n   = acc_q;
    hold_n  = hold_q;
    if (!enable || reload) begin
      acc_n  = '0;
      hold_n = 1'b0;
    end else if (os_fire) begin
      acc_n  = sum[FRAC_W-1:0];
      hold_n = sum[FRAC_W];
    end else if (pre_tick) begin
      hold_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      acc_q  <= acc_n;
      hold_q <= hold_n;
    end
  end
endmodule

// File: rtl/fbg_ratio_count.sv
// Registers the oversample strobe and marks every OSR-th one.
module fbg_ratio_count #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic os_fire,
  output logic os_tick,
  output logic bit_tick
);
  localparam int unsigned CNT_W = (OSR > 2) ? $clog2(OSR) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_inc;
  logic             last;
  logic             os_q, bit_q;

  assign last = (cnt_q == CNT_W'(OSR - 1));

  generate
    if ((OSR & (OSR - 1)) == 0) begin : g_wrap
      assign cnt_inc = cnt_q + CNT_W'(1);
    end else begin : g_cmp
      assign cnt_inc = last ? '0 : cnt_q + CNT_W'(1);
    end
  endgenerate

  always_comb begin
    if (!enable)      cnt_n = '0;
    else if (os_fire) cnt_n = cnt_inc;
    else              cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      os_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      os_q  <= enable && os_fire;
      bit_q <= enable && os_fire && last;
    end
  end

  assign os_tick  = os_q;
  assign bit_tick = bit_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int unsigned DIV_W  = DIV_W_DEF,
  parameter int unsigned THR_W  = THR_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  parameter int unsigned OSR    = OSR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [THR_W-1:0]  thr_sel,
  input  logic [FRAC_W-1:0] frac_sel,
  output logic              os_tick,
  output logic              bit_tick
);
  localparam int unsigned EXP_MAX = (2 ** DIV_W - 1) + (2 ** THR_W - 1);
  localparam int unsigned EXP_W   = $clog2(EXP_MAX + 1);
  localparam int unsigned PRE_W   = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic [EXP_W-1:0]  exp_act;
  logic [FRAC_W-1:0] frac_act;
  logic              reload;
  logic              pre_tick;
  logic              os_fire;

  fbg_cfg_hold #(
    .DIV_W(DIV_W), .THR_W(THR_W), .FRAC_W(FRAC_W), .EXP_W(EXP_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable), .boundary(os_fire),
    .div_in(div_sel), .thr_in(thr_sel), .frac_in(frac_sel),
    .exp_act(exp_act), .frac_act(frac_act), .reload(reload)
  );

  fbg_prescaler #(.EXP_W(EXP_W), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .enable(enable), .exp_act(exp_act),
    .pre_tick(pre_tick)
  );

  fbg_frac_stage #(.FRAC_W(FRAC_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pre_tick(pre_tick),
    .frac_act(frac_act), .reload(reload), .os_fire(os_fire)
  );

  fbg_ratio_count #(.OSR(OSR)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .os_fire(os_fire),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned OSR = 16
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic os_tick,
  input logic bit_tick
);
  localparam int unsigned CW = $clog2(OSR + 1);
  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= '0;
    else if (!enable)  seen_q <= '0;
    else if (bit_tick) seen_q <= '0;
    else if (os_tick)  seen_q <= seen_q + CW'(1);
  end

  assert_bit_with_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  assert_sixteen_per_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (seen_q == CW'(OSR - 1)));

  assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!os_tick && !bit_tick));

  assert_clean_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> (!os_tick && !bit_tick));

  always_comb begin
    if (!rst_n) assert_reset_quiet_R1: assert (!os_tick && !bit_tick);
  end
endmodule

bind frac_baud_gen fbg_checker #(.OSR(OSR)) u_fbg_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [2:0] div_sel;
  logic [1:0] thr_sel;
  logic [5:0] frac_sel;
  logic       os_tick;
  logic       bit_tick;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
    .thr_sel(thr_sel), .frac_sel(frac_sel), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input int d, input int t, input int f);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    div_sel  = 3'(d);
    thr_sel  = 2'(t);
    frac_sel = 6'(f);
    @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic wait_os();
    do @(negedge clk); while (!os_tick);
  endtask

  task automatic next_gap(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!os_tick);
  endtask

  task automatic measure_bits(input int nb, output longint cycles);
    int k = 0;
    do @(negedge clk); while (!bit_tick);
    cycles = 0;
    while (k < nb) begin
      @(negedge clk);
      cycles++;
      if (bit_tick) k++;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1;
    div_sel = '0; thr_sel = '0; frac_sel = '0;
    repeat (5) @(negedge clk);
    check(!os_tick && !bit_tick, "R1 reset quiet", {os_tick, bit_tick}, 0);
    enable = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!os_tick && !bit_tick, "R1 after release", {os_tick, bit_tick}, 0);
  endtask

  task automatic t_disabled();
    int ticks = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (os_tick || bit_tick) ticks++;
    end
    check(ticks == 0, "R6 no ticks while disabled", ticks, 0);
  endtask

  task automatic t_start();
    int n = 0;
    int cnt = 1;
    int ticks = 0;
    restart(1, 1, 0);
    do begin
      @(negedge clk);
      n++;
    end while (!os_tick && n < 100);
    check(n == 4, "R6 first tick latency", n, 4);
    while (!bit_tick && cnt < 100) begin
      @(negedge clk);
      if (os_tick) cnt++;
    end
    check(cnt == 16, "R5 bit tick on 16th os tick", cnt, 16);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      if (os_tick || bit_tick) ticks++;
      @(negedge clk);
    end
    check(ticks == 0, "R6 silent after disable", ticks, 0);
  endtask

  task automatic t_fast();
    int high = 0;
    longint c;
    restart(0, 0, 0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (os_tick) high++;
    end
    check(high == 20, "R2 exp 0 strobe always high", high, 20);
    measure_bits(4, c);
    check(c == 64, "R5 exp 0 bit period", c, 64);
  endtask

  task automatic t_rate(input int d, input int t, input int f, input int nb,
                        input string req, output longint c);
    longint expv;
    int e = d + t;
    restart(d, t, f);
    measure_bits(nb, c);
    expv = (longint'(nb) * 16 * (longint'(1) << e) * (64 + f)) / 64;
    check((c - expv <= nb) && (expv - c <= nb), req, c, expv);
  endtask

  task automatic t_gaps();
    int g;
    int bad = 0;
    int longs = 0;
    restart(1, 0, 32);
    wait_os();
    for (int i = 0; i < 64; i++) begin
      next_gap(g);
      if (g == 4) longs++;
      else if (g != 2) bad++;
    end
    check(bad == 0, "R4 gaps only 2 or 4", bad, 0);
    check(longs == 32, "R4 long gap count", longs, 32);
  endtask

  task automatic t_change();
    int g;
    int bad = 0;
    restart(3, 0, 0);
    wait_os();
    next_gap(g);
    check(g == 8, "R2 exp 3 period", g, 8);
    div_sel = 3'd1;
    next_gap(g);
    check(g == 8, "R7 old period completes", g, 8);
    for (int i = 0; i < 5; i++) begin
      next_gap(g);
      if (g != 2) bad++;
    end
    check(bad == 0, "R7 new period after boundary", bad, 0);
  endtask

  initial begin
    longint c;
    t_reset();
    t_disabled();
    t_start();
    t_fast();
    t_rate(3, 1, 43, 8, "R3 exp 4 frac 0x2B", c);
    check(4096000 * 8 / c == 9570, "R8 9600 example bps", 4096000 * 8 / c, 9570);
    check(c == 3424, "R8 example bit period", c, 3424);
    t_rate(1, 1, 63, 4, "R3 exp 2 frac 63", c);
    t_rate(0, 0, 63, 4, "R3 exp 0 frac 63", c);
    t_rate(7, 3, 0, 2, "R2 exp 10 via both fields", c);
    t_gaps();
    t_change();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule